// File: doc/BRIEF.md
# Preamble-Synchronized Byte Framer

This block sits between a bit-level decoder and a packet layer. It accepts one decoded bit per `bit_vld_i` strobe, plus a gap indication that the decoder raises when the line has been quiet for too long. After reset, and after every gap, the framer is in a hunt state. It keeps a short history of recent bits and waits for a synchronization pattern: four ones followed by a zero.

When the pattern appears, the trailing zero becomes the start bit of the first character. The framer switches to collecting fixed 11-bit characters. Each character holds a start bit, eight data bits sent least significant bit first, an odd-parity bit and a stop bit.

For every completed character the framer presents the data byte with a one-cycle valid strobe. It also raises separate flags for a bad start bit, bad parity and a bad stop bit. A one-cycle packet-start pulse marks each new synchronization, so that the packet layer can drop whatever it had gathered. Only a gap returns the framer to the hunt state.

Top module: `preamble_byte_framer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `byte_vld_o`, `pkt_start_o` and all three error flags are 0, and `byte_o` is 0x00.
- R2: In the hunt state, suppose the five most recent accepted bits, oldest first, are 1,1,1,1,0. Then `pkt_start_o` is 1 for exactly one cycle, in the cycle after the clock edge that accepted the 0. The framer then enters the data state, with that 0 counted as the start bit of the first character.
- R3: A run of fewer than four ones before a 0 does not synchronize. A longer run of ones before the 0 does synchronize, because only the last five bits count. Any history gathered before entering the data state, or before a gap, is discarded.
- R4: In the data state every character is exactly 11 accepted bits, in this order: start, data bit 0 to data bit 7, parity, stop. The first character consists of the synchronizing 0 plus the next 10 bits. Later characters follow without any gap between them.
- R5: Data bits arrive least significant bit first. The first data bit after the start bit is `byte_o[0]`.
- R6: `byte_vld_o` is 1 for one cycle, in the cycle after the edge that accepted the stop bit. Between strobes, `byte_o` keeps its last delivered value.
- R7: The expected parity bit is the inverse of the XOR of the eight data bits. `parity_err_o` is 1 with the strobe when the received parity bit differs from this value.
- R8: `start_err_o` is 1 when the start bit is 1, and `stop_err_o` is 1 when the stop bit is 0. The byte is delivered in either case. All flags are 0 outside the `byte_vld_o` cycle.
- R9: `gap_i` high at a clock edge returns the framer to the hunt state. It discards the partial character and the hunt history. If `bit_vld_i` is high in the same cycle, that bit is dropped, and no strobe follows that edge.
- R10: When `bit_vld_i` is low, `bit_i` has no effect on the outputs or on the framing.
- R11: A 1,1,1,1,0 pattern inside the data state is treated as character bits. It produces no `pkt_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | A decoded bit is present on `bit_i` |
| bit_i | input | 1 | Decoded bit value |
| gap_i | input | 1 | Over-long interval seen; return to hunt |
| byte_vld_o | output | 1 | One-cycle strobe for a completed character |
| byte_o | output | 8 | Data byte, held between strobes |
| start_err_o | output | 1 | Start bit was 1 (only with the strobe) |
| parity_err_o | output | 1 | Parity mismatch (only with the strobe) |
| stop_err_o | output | 1 | Stop bit was 0 (only with the strobe) |
| pkt_start_o | output | 1 | One-cycle pulse on each synchronization |

## Verification
Every result in this block is due exactly one cycle after the edge that accepted the bit that completes it. For `pkt_start_o` that bit is the synchronizing zero. For `byte_vld_o`, `byte_o` and the three flags it is the stop bit. A gap takes effect at the same edge at which it is sampled.

The bench applies each input set on a falling edge and advances a behavioural queue model at the following rising edge. At the next falling edge it compares every output with the model, so every cycle is checked at the point where its result is due. Stimulus covers the sync run lengths, errored characters, gaps in mid-character and gaps colliding with a bit, and a long random stream.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_DATA = 1'b1
  } fr_state_e;
endpackage

// File: rtl/pf_sync_hunter.sv
module pf_sync_hunter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic hit_o
);
  // history of prior accepted bits; cleared entries read as zero, never match
  logic [RUN_LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (clr_i)   hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[RUN_LEN-2:0], bit_i};
  end

  assign hit_o = shift_i & ~bit_i & (&hist_q);
endmodule

// File: rtl/pf_char_shift.sv
module pf_char_shift #(
  parameter int FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (load_i) begin
      // sync zero doubles as start bit of the first character
      sreg_q[0] <= 1'b0;
      cnt_q     <= CNT_W'(1);
    end else if (shift_i) begin
      sreg_q[cnt_q] <= bit_i;
      cnt_q         <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign done_o = shift_i & ~clr_i & ~load_i & (cnt_q == LAST);

  always_comb begin
    frame_o            = sreg_q;
    frame_o[FRAME_W-1] = bit_i;
  end
endmodule

// File: rtl/pf_char_check.sv
module pf_char_check #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W+2:0] frame_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              start_err_o,
  output logic              parity_err_o,
  output logic              stop_err_o
);
  localparam int PAR_POS  = DATA_W + 1;
  localparam int STOP_POS = DATA_W + 2;

  logic [DATA_W-1:0] data;
  logic              par_exp;

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign data[i] = frame_i[1+i];
  end

  assign par_exp = ~(^data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      byte_o       <= '0;
      start_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      stop_err_o   <= 1'b0;
    end else begin
      vld_o        <= done_i;
      start_err_o  <= done_i & frame_i[0];
      parity_err_o <= done_i & (frame_i[PAR_POS] ^ par_exp);
      stop_err_o   <= done_i & ~frame_i[STOP_POS];
      if (done_i) byte_o <= data;
    end
  end
endmodule

// File: rtl/preamble_byte_framer.sv
module preamble_byte_framer
  import pf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              gap_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              start_err_o,
  output logic              parity_err_o,
  output logic              stop_err_o,
  output logic              pkt_start_o
);
  localparam int FRAME_W = DATA_W + 3;

  fr_state_e          state_q, state_d;
  logic               take;
  logic               hunt_shift, hunt_hit;
  logic               char_shift, char_done;
  logic [FRAME_W-1:0] frame;
  logic               pkt_q;

  assign take       = bit_vld_i & ~gap_i;
  assign hunt_shift = take & (state_q == ST_HUNT);
  assign char_shift = take & (state_q == ST_DATA);

  always_comb begin
    state_d = state_q;
    if (gap_i)         state_d = ST_HUNT;
    else if (hunt_hit) state_d = ST_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pkt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pkt_q   <= hunt_hit & ~gap_i;
    end
  end

  pf_sync_hunter #(.RUN_LEN(RUN_LEN)) u_hunt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (gap_i | hunt_hit),
    .shift_i (hunt_shift),
    .bit_i   (bit_i),
    .hit_o   (hunt_hit)
  );

  pf_char_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (gap_i),
    .load_i  (hunt_hit),
    .shift_i (char_shift),
    .bit_i   (bit_i),
    .done_o  (char_done),
    .frame_o (frame)
  );

  pf_char_check #(.DATA_W(DATA_W)) u_check (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (char_done),
    .frame_i      (frame),
    .vld_o        (byte_vld_o),
    .byte_o       (byte_o),
    .start_err_o  (start_err_o),
    .parity_err_o (parity_err_o),
    .stop_err_o   (stop_err_o)
  );

  assign pkt_start_o = pkt_q;
endmodule

// File: rtl/pf_framer_sva.sv
module pf_framer_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_vld_i,
  input logic              bit_i,
  input logic              gap_i,
  input logic              byte_vld_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              start_err_o,
  input logic              parity_err_o,
  input logic              stop_err_o,
  input logic              pkt_start_o
);
  p_sync_on_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> $past(bit_vld_i && !bit_i && !gap_i));

  p_sync_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |=> !pkt_start_o);

  p_strobe_after_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_vld_i && !gap_i));

  p_byte_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(byte_o));

  p_flags_with_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_err_o || parity_err_o || stop_err_o) |-> byte_vld_o);

  p_gap_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_i |=> (!byte_vld_o && !pkt_start_o));

  p_no_bit_no_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> (!byte_vld_o && !pkt_start_o));

  p_sync_not_with_byte_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_start_o && byte_vld_o));
endmodule

bind preamble_byte_framer pf_framer_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_vld_i    (bit_vld_i),
  .bit_i        (bit_i),
  .gap_i        (gap_i),
  .byte_vld_o   (byte_vld_o),
  .byte_o       (byte_o),
  .start_err_o  (start_err_o),
  .parity_err_o (parity_err_o),
  .stop_err_o   (stop_err_o),
  .pkt_start_o  (pkt_start_o)
);

// File: tb/tb_preamble_byte_framer.sv
`timescale 1ns/1ps
module tb_preamble_byte_framer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_vld_i = 1'b0, bit_i = 1'b0, gap_i = 1'b0;
  logic       byte_vld_o, start_err_o, parity_err_o, stop_err_o, pkt_start_o;
  logic [7:0] byte_o;

  always #2.5 clk_i = ~clk_i;

  preamble_byte_framer dut (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .gap_i,
    .byte_vld_o, .byte_o, .start_err_o, .parity_err_o, .stop_err_o, .pkt_start_o
  );

  int total = 0, bad = 0;

  // reference model state
  int   hist[$];
  int   frm[$];
  bit   in_data = 0;
  bit   e_vld = 0, e_pkt = 0, e_se = 0, e_pe = 0, e_oe = 0;
  logic [7:0] e_byte = 8'h00;

  task automatic model();
    e_vld = 0; e_pkt = 0; e_se = 0; e_pe = 0; e_oe = 0;
    if (gap_i) begin
      in_data = 0; hist.delete(); frm.delete();
    end else if (bit_vld_i) begin
      if (!in_data) begin
        hist.push_back(int'(bit_i));
        if (hist.size() > 5) void'(hist.pop_front());
        if (hist.size() == 5 && hist[0] == 1 && hist[1] == 1 && hist[2] == 1 &&
            hist[3] == 1 && hist[4] == 0) begin
          in_data = 1; hist.delete(); frm.delete(); frm.push_back(0); e_pkt = 1;
        end
      end else begin
        frm.push_back(int'(bit_i));
        if (frm.size() == 11) begin
          int p;
          p = 1;
          for (int i = 0; i < 8; i++) begin
            e_byte[i] = frm[1+i][0];
            p ^= frm[1+i];
          end
          e_vld = 1;
          e_se  = (frm[0] != 0);
          e_pe  = (frm[9] != p);
          e_oe  = (frm[10] != 1);
          frm.delete();
        end
      end
    end
  endtask

  task automatic compare(string tag);
    total++;
    if (byte_vld_o !== e_vld || byte_o !== e_byte || start_err_o !== e_se ||
        parity_err_o !== e_pe || stop_err_o !== e_oe || pkt_start_o !== e_pkt) begin
      bad++;
      $display("FAIL %s t=%0t got vld=%0b byte=%02h se=%0b pe=%0b oe=%0b pkt=%0b exp vld=%0b byte=%02h se=%0b pe=%0b oe=%0b pkt=%0b",
               tag, $time, byte_vld_o, byte_o, start_err_o, parity_err_o, stop_err_o, pkt_start_o,
               e_vld, e_byte, e_se, e_pe, e_oe, e_pkt);
    end
  endtask

  task automatic step(bit v, bit b, bit g, string tag);
    bit_vld_i = v; bit_i = b; gap_i = g;
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic put_bit(bit b, string tag);
    int idle;
    idle = $urandom_range(0, 2);
    for (int k = 0; k < idle; k++) step(1'b0, 1'($urandom_range(0, 1)), 1'b0, "R10");
    step(1'b1, b, 1'b0, tag);
  endtask

  task automatic sync(int ones, string tag);
    for (int k = 0; k < ones; k++) put_bit(1'b1, tag);
    put_bit(1'b0, tag);
  endtask

  // rest of a character after its start bit
  task automatic tail(logic [7:0] d, bit pflip, bit stop, string tag);
    for (int k = 0; k < 8; k++) put_bit(d[k], tag);
    put_bit(~(^d) ^ pflip, tag);
    put_bit(stop, tag);
  endtask

  task automatic full_char(logic [7:0] d, bit start, bit pflip, bit stop, string tag);
    put_bit(start, tag);
    tail(d, pflip, stop, tag);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 60000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1 after reset");

    // R10: bits without valid strobe ignored
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, "R10");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, "R10");

    // R3: short run does not sync
    sync(3, "R3 short run");
    step(1'b1, 1'b1, 1'b1, "R9 gap in hunt");
    // R2: exact run, R4/R5/R7 first char from sync zero
    sync(4, "R2 sync");
    tail(8'hA5, 1'b0, 1'b1, "R5 lsb first");
    full_char(8'h3C, 1'b0, 1'b0, 1'b1, "R4 back-to-back");
    full_char(8'h01, 1'b0, 1'b1, 1'b1, "R7 parity error");
    full_char(8'hFE, 1'b1, 1'b0, 1'b1, "R8 start error");
    full_char(8'h80, 1'b0, 1'b0, 1'b0, "R8 stop error");
    full_char(8'hF0, 1'b0, 1'b0, 1'b1, "R11 pattern inside data");
    full_char(8'h0F, 1'b1, 1'b1, 1'b0, "R8 all errors");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b0, "R6 hold");

    // R9: gap mid-character, then long run resync (R3)
    put_bit(1'b0, "R9"); put_bit(1'b1, "R9"); put_bit(1'b1, "R9");
    step(1'b0, 1'b0, 1'b1, "R9 gap mid char");
    sync(7, "R3 long run");
    tail(8'h5A, 1'b0, 1'b1, "R4 after resync");
    // R9: gap collides with a stop bit
    put_bit(1'b0, "R9");
    for (int k = 0; k < 9; k++) put_bit(1'b1, "R9");
    step(1'b1, 1'b1, 1'b1, "R9 gap drops stop bit");
    // history cleared by gap: two ones before, three after, then zero => no sync
    put_bit(1'b1, "R3"); put_bit(1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, "R3 gap clears history");
    sync(3, "R3 history cleared");
    sync(4, "R2 sync again");
    tail(8'hC3, 1'b0, 1'b1, "R7 good parity");

    // random stream
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 70, 1'($urandom_range(0, 1)) | (r < 35), r >= 98, "R4 random");
    end

    summary();
    $finish;
  end
endmodule